// File: doc/BRIEF.md
# Host and Management-Controller Mailbox

This block is a small register file shared by two bus masters: an application processor (the host) and an always-on management microcontroller (the MCU). Each side has its own 32-bit slave port. Each direction of travel has two words, a command and a parameter. The host posts a request by writing its parameter and then its command word. The MCU then sees a one-cycle new-command strobe and a pending level.

The MCU reports completion in-band. It writes a done flag and a 14-bit reply code into the upper bits of the same command word the host wrote, so the host polls that one word and needs no separate status register.

In the other direction, the MCU posts a message by writing its outbound command word. That write latches a sticky pending bit for the host. The pending bit, ANDed with an enable bit, drives the host interrupt line until the host clears it.

Top module: `mbox_regs`

## Requirements
- R1: After reset every register reads 0 on both ports, `host_irq` is 0, and `mcu_cmd_pending` and `mcu_cmd_strobe` are 0.
- R2: A host write to offset 0x0 stores bits 30 and 15:0 of the write data. The same write forces bit 31 (done) and bits 29:16 (reply) to 0, whatever the data. Offset 0x4 is a host read/write parameter word.
- R3: A host write to 0x0 makes `mcu_cmd_strobe` 1 for exactly the cycle after the write cycle. It sets `mcu_cmd_pending` from that same cycle, and pending holds until cleared as R4 describes.
- R4: An MCU write to offset 0x0 loads bit 31 and bits 29:16 from its data and leaves bits 30 and 15:0 unchanged. If data bit 31 is 1, the write clears `mcu_cmd_pending`. The host reads the result at 0x0.
- R5: When a host write to 0x0 and an MCU write to 0x0 fall in the same cycle, the host write wins: done and reply read 0 and pending is 1.
- R6: The MCU writes its outbound command at MCU offset 0x8 and its outbound parameter at MCU offset 0xC. The host reads them at the same offsets, and host writes to 0x8 and 0xC are ignored.
- R7: An MCU write to 0x8 sets bit 0 of the host status word at offset 0x34. The bit stays set until the host clears it.
- R8: A host write with bit 0 set to offset 0x3C clears the status bit, and a write with bit 0 clear has no effect. When an MCU write to 0x8 lands in the same cycle as a clear, the set wins.
- R9: `host_irq` is 1 exactly when the status bit and the enable bit (host offset 0x38, bit 0, read/write) are both 1.
- R10: Host reads of offset 0x3C and of unmapped offsets return 0, and host writes to unmapped offsets change nothing. Bits 31:1 of offsets 0x34 and 0x38 read 0.
- R11: The MCU port reads the host command and parameter words at its offsets 0x0 and 0x4. MCU writes to 0x4 and to unmapped offsets are ignored, and unmapped MCU reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host port access select |
| h_wr | input | 1 | Host port write (with h_sel) |
| h_addr | input | AW | Host port byte offset |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data for h_addr |
| m_sel | input | 1 | MCU port access select |
| m_wr | input | 1 | MCU port write (with m_sel) |
| m_addr | input | AW | MCU port byte offset |
| m_wdata | input | 32 | MCU port write data |
| m_rdata | output | 32 | MCU port read data for m_addr |
| host_irq | output | 1 | Host interrupt, status AND enable |
| mcu_cmd_strobe | output | 1 | One-cycle new-command pulse to the MCU |
| mcu_cmd_pending | output | 1 | Host command awaiting MCU completion |

## Verification
Writes take effect at the clock edge that ends the write cycle. Read data is combinational from the address, so a write's result can be read back one cycle after the write. `mcu_cmd_strobe`, `mcu_cmd_pending` and `host_irq` likewise change in the cycle after the write that causes them. The bench drives inputs 1 ns after a rising edge. It waits for the following edge plus 1 ns before it samples any output, so every check falls in the first cycle in which the result is due. For the strobe, the bench also checks the cycle after that, to prove the pulse is one cycle wide.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W = 32;

    // Byte offsets (both ports share the same layout of words)
    localparam logic [7:0] OFF_REQ_CMD   = 8'h00;
    localparam logic [7:0] OFF_REQ_PARAM = 8'h04;
    localparam logic [7:0] OFF_RSP_CMD   = 8'h08;
    localparam logic [7:0] OFF_RSP_PARAM = 8'h0C;
    localparam logic [7:0] OFF_STAT      = 8'h34;
    localparam logic [7:0] OFF_ENA       = 8'h38;
    localparam logic [7:0] OFF_ACK       = 8'h3C;

    // Ownership of the request command word
    localparam int DONE_BIT  = 31;
    localparam int REPLY_LSB = 16;
    localparam int REPLY_W   = 14;
    localparam logic [DATA_W-1:0] HOST_OWN_MASK = 32'h4000_FFFF;
    localparam logic [DATA_W-1:0] MCU_OWN_MASK  = 32'hBFFF_0000;

    typedef struct packed {
        logic req_cmd;
        logic req_param;
        logic ena;
        logic ack;
    } host_we_t;

    typedef struct packed {
        logic done;
        logic rsp_cmd;
        logic rsp_param;
    } mcu_we_t;

    function automatic logic [REPLY_W-1:0] reply_of(input logic [DATA_W-1:0] w);
        return w[REPLY_LSB +: REPLY_W];
    endfunction

endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
    import mbox_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] req_cmd,
    input  logic [DATA_W-1:0] req_param,
    input  logic [DATA_W-1:0] rsp_cmd,
    input  logic [DATA_W-1:0] rsp_param,
    input  logic              stat,
    input  logic              ena,
    output host_we_t          we,
    output logic [DATA_W-1:0] rdata
);
    logic wr_act;
    assign wr_act = sel & wr;

    always_comb begin
        we           = '0;
        we.req_cmd   = wr_act && (addr == AW'(OFF_REQ_CMD));
        we.req_param = wr_act && (addr == AW'(OFF_REQ_PARAM));
        we.ena       = wr_act && (addr == AW'(OFF_ENA));
        we.ack       = wr_act && (addr == AW'(OFF_ACK));
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFF_REQ_CMD))        rdata = req_cmd;
        else if (addr == AW'(OFF_REQ_PARAM)) rdata = req_param;
        else if (addr == AW'(OFF_RSP_CMD))   rdata = rsp_cmd;
        else if (addr == AW'(OFF_RSP_PARAM)) rdata = rsp_param;
        else if (addr == AW'(OFF_STAT))      rdata = {{(DATA_W-1){1'b0}}, stat};
        else if (addr == AW'(OFF_ENA))       rdata = {{(DATA_W-1){1'b0}}, ena};
    end
endmodule

// File: rtl/mbox_mcu_dec.sv
module mbox_mcu_dec
    import mbox_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] req_cmd,
    input  logic [DATA_W-1:0] req_param,
    input  logic [DATA_W-1:0] rsp_cmd,
    input  logic [DATA_W-1:0] rsp_param,
    output mcu_we_t           we,
    output logic [DATA_W-1:0] rdata
);
    logic wr_act;
    assign wr_act = sel & wr;

    always_comb begin
        we           = '0;
        we.done      = wr_act && (addr == AW'(OFF_REQ_CMD));
        we.rsp_cmd   = wr_act && (addr == AW'(OFF_RSP_CMD));
        we.rsp_param = wr_act && (addr == AW'(OFF_RSP_PARAM));
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFF_REQ_CMD))        rdata = req_cmd;
        else if (addr == AW'(OFF_REQ_PARAM)) rdata = req_param;
        else if (addr == AW'(OFF_RSP_CMD))   rdata = rsp_cmd;
        else if (addr == AW'(OFF_RSP_PARAM)) rdata = rsp_param;
    end
endmodule

// File: rtl/mbox_req_word.sv
module mbox_req_word
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              mcu_we,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] word,
    output logic              strobe,
    output logic              pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            strobe  <= 1'b0;
            pending <= 1'b0;
        end else if (host_we) begin
            word    <= host_wdata & HOST_OWN_MASK;
            strobe  <= 1'b1;
            pending <= 1'b1;
        end else begin
            strobe <= 1'b0;
            if (mcu_we) begin
                word <= (word & HOST_OWN_MASK) | (mcu_wdata & MCU_OWN_MASK);
                if (mcu_wdata[DONE_BIT]) pending <= 1'b0;
            end
        end
    end

    AST_HOST_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        host_we |=> (!word[DONE_BIT] && reply_of(word) == '0)); // R2
    AST_STROBE_WITH_PENDING: assert property (@(posedge clk) disable iff (rst)
        strobe |-> pending); // R3
    AST_MCU_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (mcu_we && !host_we) |=> (word[15:0] == $past(word[15:0]))); // R4
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        (host_we && mcu_we) |=> (pending && !word[DONE_BIT])); // R5
endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack_we,
    input  logic ack_bit,
    input  logic ena_we,
    input  logic ena_bit,
    output logic stat,
    output logic ena
);
    logic do_clear;
    assign do_clear = ack_we & ack_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= 1'b0;
            ena  <= 1'b0;
        end else begin
            if (set)           stat <= 1'b1;
            else if (do_clear) stat <= 1'b0;
            if (ena_we)        ena  <= ena_bit;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> stat); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat && !do_clear) |=> stat); // R7
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic [AW-1:0]     h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              m_sel,
    input  logic              m_wr,
    input  logic [AW-1:0]     m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    output logic              host_irq,
    output logic              mcu_cmd_strobe,
    output logic              mcu_cmd_pending
);
    host_we_t          hwe;
    mcu_we_t           mwe;
    logic [DATA_W-1:0] req_cmd, req_param, rsp_cmd, rsp_param;
    logic              stat, ena;

    mbox_host_dec #(.AW(AW)) u_hdec (
        .sel(h_sel), .wr(h_wr), .addr(h_addr),
        .req_cmd(req_cmd), .req_param(req_param),
        .rsp_cmd(rsp_cmd), .rsp_param(rsp_param),
        .stat(stat), .ena(ena), .we(hwe), .rdata(h_rdata)
    );

    mbox_mcu_dec #(.AW(AW)) u_mdec (
        .sel(m_sel), .wr(m_wr), .addr(m_addr),
        .req_cmd(req_cmd), .req_param(req_param),
        .rsp_cmd(rsp_cmd), .rsp_param(rsp_param),
        .we(mwe), .rdata(m_rdata)
    );

    mbox_req_word u_req (
        .clk(clk), .rst(rst),
        .host_we(hwe.req_cmd), .host_wdata(h_wdata),
        .mcu_we(mwe.done), .mcu_wdata(m_wdata),
        .word(req_cmd), .strobe(mcu_cmd_strobe), .pending(mcu_cmd_pending)
    );

    mbox_irq_ctl u_irq (
        .clk(clk), .rst(rst),
        .set(mwe.rsp_cmd),
        .ack_we(hwe.ack), .ack_bit(h_wdata[0]),
        .ena_we(hwe.ena), .ena_bit(h_wdata[0]),
        .stat(stat), .ena(ena)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_param <= '0;
            rsp_cmd   <= '0;
            rsp_param <= '0;
        end else begin
            if (hwe.req_param) req_param <= h_wdata;
            if (mwe.rsp_cmd)   rsp_cmd   <= m_wdata;
            if (mwe.rsp_param) rsp_param <= m_wdata;
        end
    end

    assign host_irq = stat & ena;

    AST_RSP_CMD_LOADS: assert property (@(posedge clk) disable iff (rst)
        (m_sel && m_wr && m_addr == AW'(OFF_RSP_CMD)) |=> (rsp_cmd == $past(m_wdata))); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (h_sel && h_wr && h_addr == AW'(OFF_ENA) && !h_wdata[0]) |=> !host_irq); // R9
endmodule

// File: tb/tb_mbox_regs.sv
`timescale 1ns/1ps
module tb_mbox_regs;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        h_sel, h_wr, m_sel, m_wr;
    logic [7:0]  h_addr, m_addr;
    logic [31:0] h_wdata, m_wdata, h_rdata, m_rdata;
    logic        host_irq, mcu_cmd_strobe, mcu_cmd_pending;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mbox_regs #(.AW(AW)) dut (
        .clk(clk), .rst(rst),
        .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .m_sel(m_sel), .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .host_irq(host_irq), .mcu_cmd_strobe(mcu_cmd_strobe), .mcu_cmd_pending(mcu_cmd_pending)
    );

    // vector: {write on mcu port, waddr, wdata, read on mcu port, raddr, expected}
    typedef struct packed {
        logic        wm;
        logic [7:0]  wa;
        logic [31:0] wd;
        logic        rm;
        logic [7:0]  ra;
        logic [31:0] rx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h04, 32'hA5A5_0001, 1'b0, 8'h04, 32'hA5A5_0001}, // R2 param
        '{1'b0, 8'h00, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h4000_FFFF}, // R2 masks
        '{1'b1, 8'h00, 32'h8123_4567, 1'b0, 8'h00, 32'hC123_FFFF}, // R4 done+reply
        '{1'b0, 8'h08, 32'h0000_1234, 1'b0, 8'h08, 32'h0000_0000}, // R6 host ignored
        '{1'b1, 8'h08, 32'h0000_0102, 1'b0, 8'h08, 32'h0000_0102}, // R6
        '{1'b1, 8'h0C, 32'hDEAD_BEEF, 1'b0, 8'h0C, 32'hDEAD_BEEF}, // R6
        '{1'b0, 8'h3C, 32'h0000_0000, 1'b0, 8'h34, 32'h0000_0001}, // R7 R8 no clear
        '{1'b0, 8'h38, 32'hFFFF_FFFF, 1'b0, 8'h38, 32'h0000_0001}, // R9 R10
        '{1'b0, 8'h3C, 32'h0000_0001, 1'b0, 8'h34, 32'h0000_0000}, // R8 clear
        '{1'b0, 8'h20, 32'hFFFF_FFFF, 1'b0, 8'h20, 32'h0000_0000}, // R10
        '{1'b1, 8'h04, 32'h0000_0005, 1'b1, 8'h04, 32'hA5A5_0001}, // R11
        '{1'b1, 8'h30, 32'h0000_0007, 1'b0, 8'h3C, 32'h0000_0000}  // R10 R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        h_sel = 0; h_wr = 0; m_sel = 0; m_wr = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
    endtask

    task automatic mwrite(input logic [7:0] a, input logic [31:0] d);
        m_sel = 1; m_wr = 1; m_addr = a; m_wdata = d;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        h_addr = a; #0.1; d = h_rdata;
    endtask

    task automatic mread(input logic [7:0] a, output logic [31:0] d);
        m_addr = a; #0.1; d = m_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        idle();
        h_addr = 0; m_addr = 0; h_wdata = 0; m_wdata = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        foreach (VEC[i]) begin
            hread(VEC[i].ra, rd);
            check("R1 host read after reset", rd, 32'h0);
        end
        mread(8'h00, rd); check("R1 mcu read after reset", rd, 32'h0);
        check("R1 irq", {31'h0, host_irq}, 32'h0);
        check("R1 pending", {30'h0, mcu_cmd_strobe, mcu_cmd_pending}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wm) mwrite(VEC[i].wa, VEC[i].wd);
            else           hwrite(VEC[i].wa, VEC[i].wd);
            step();
            idle();
            if (VEC[i].rm) mread(VEC[i].ra, rd);
            else           hread(VEC[i].ra, rd);
            check($sformatf("vector %0d", i), rd, VEC[i].rx);
        end

        // R3 strobe and pending timing
        hwrite(8'h00, 32'h0000_00AA);
        step(); idle();
        check("R3 strobe due", {31'h0, mcu_cmd_strobe}, 32'h1);
        check("R3 pending set", {31'h0, mcu_cmd_pending}, 32'h1);
        step();
        check("R3 strobe one cycle", {31'h0, mcu_cmd_strobe}, 32'h0);
        check("R3 pending held", {31'h0, mcu_cmd_pending}, 32'h1);

        // R4 reply without done keeps pending, done clears it
        mwrite(8'h00, 32'h0005_FFFF);
        step(); idle();
        check("R4 pending kept", {31'h0, mcu_cmd_pending}, 32'h1);
        hread(8'h00, rd); check("R4 reply only", rd, 32'h0005_00AA);
        mwrite(8'h00, 32'h8000_0000);
        step(); idle();
        check("R4 pending cleared", {31'h0, mcu_cmd_pending}, 32'h0);
        mread(8'h00, rd); check("R4 mcu sees done", rd, 32'h8000_00AA);

        // R5 collision on command word
        hwrite(8'h00, 32'h0000_0011);
        mwrite(8'h00, 32'hBFFF_0000);
        step(); idle();
        hread(8'h00, rd); check("R5 host wins word", rd, 32'h0000_0011);
        check("R5 pending", {31'h0, mcu_cmd_pending}, 32'h1);

        // R8 set beats clear in same cycle; R9 irq follows enable
        mwrite(8'h08, 32'h0000_0777);
        hwrite(8'h3C, 32'h0000_0001);
        step(); idle();
        hread(8'h34, rd); check("R8 set wins", rd, 32'h1);
        check("R9 irq on", {31'h0, host_irq}, 32'h1);
        hwrite(8'h38, 32'h0000_0000);
        step(); idle();
        check("R9 irq gated off", {31'h0, host_irq}, 32'h0);
        hread(8'h34, rd); check("R7 status sticky", rd, 32'h1);
        hwrite(8'h38, 32'h0000_0001);
        step(); idle();
        check("R9 irq back on", {31'h0, host_irq}, 32'h1);
        hwrite(8'h3C, 32'h0000_0001);
        step(); idle();
        check("R8 irq cleared", {31'h0, host_irq}, 32'h0);

        // R10 unmapped host write left registers alone
        hread(8'h04, rd); check("R10 param intact", rd, 32'hA5A5_0001);
        mread(8'h34, rd); check("R11 mcu unmapped read", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule